// File: doc/BRIEF.md
# I2C 10-bit Slave Address Sequencer

This block follows the two-byte address handshake of an I2C slave that answers to a 10-bit address. It sits next to a byte receiver. The receiver reports Start, Repeated Start and Stop events. It also gives a strobe at the falling edge of the ninth SCL pulse of each byte, together with the byte it has just shifted in. The sequencer compares each address byte against a single comparison register that the host loads.

After a matching high byte, the sequencer stretches SCL and raises an update-address flag. The host then writes the low address byte into the register, which releases the clock. After a matching low byte, the sequencer stretches and flags again. The host restores the high byte, and the slave counts as addressed for a write. For a read, the bus master issues a Repeated Start and sends the high byte again with the read bit set. If that byte matches, the slave is addressed for a read and no stretch occurs.

The states are:
- IDLE: nothing in progress.
- HDR: waiting for the high byte after a Start.
- HI_HOLD: stretching after the high byte.
- LO_WAIT: waiting for the low byte.
- LO_HOLD: stretching after the low byte.
- WR_XFER: addressed for a write.
- RS_HDR: waiting for the high byte again after a Repeated Start.
- RD_XFER: addressed for a read.

The transitions are:
- Start: any state goes to HDR.
- Stop: any state goes to IDLE.
- Repeated Start: WR_XFER or RD_XFER goes to RS_HDR; any other state goes to HDR.
- High byte in HDR: a match with write goes to HI_HOLD; anything else goes to IDLE.
- Host write in HI_HOLD: goes to LO_WAIT.
- Low byte in LO_WAIT: a match goes to LO_HOLD; a mismatch goes to IDLE.
- Host write in LO_HOLD: goes to WR_XFER.
- High byte in RS_HDR: a match with read goes to RD_XFER; a match with write goes to HI_HOLD; a mismatch goes to IDLE.

Top module: `i2c10_addr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, scl_hold_o, upd_addr_o, matched_o and match_rd_o are all low, and the comparison register holds RST_ADDR.
- R2: In HDR, a byte whose bits 7:3 are 11110, whose bits 2:1 equal register bits 2:1 and whose bit 0 is 0 (write) raises scl_hold_o and upd_addr_o in the cycle after the strobe.
- R3: In HDR, a byte with bit 0 = 1, a wrong 11110 prefix or wrong bits 2:1 sends the sequencer to IDLE with no hold. Later byte strobes are ignored until the next Start.
- R4: scl_hold_o and upd_addr_o stay high until the host write strobe. They are both low in the cycle after that write.
- R5: In LO_WAIT, a byte equal to all 8 register bits raises scl_hold_o and upd_addr_o in the next cycle. Any other byte returns the sequencer to IDLE.
- R6: The host write that ends the low-byte hold raises matched_o with match_rd_o low. Data byte strobes afterwards leave this unchanged.
- R7: After a Repeated Start in WR_XFER or RD_XFER, a resent high byte with bit 0 = 1 and bits 7:1 equal to register bits 7:1 raises matched_o and match_rd_o, without asserting scl_hold_o.
- R8: After such a Repeated Start, a resent high byte that fails the comparison leaves all outputs low.
- R9: A Stop returns the sequencer to IDLE with all outputs low in the next cycle. Stop wins over a Start, Repeated Start, byte strobe or write in the same cycle, but a write in that cycle still loads the register.
- R10: A Start in any state drops any match or hold and waits for a new high byte.
- R11: A host write outside the two hold states loads the register and changes no output.
- R12: A Repeated Start outside WR_XFER and RD_XFER behaves like a Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start condition seen (one cycle) |
| rstart_i | input | 1 | Repeated Start seen (one cycle) |
| stop_i | input | 1 | Stop condition seen (one cycle) |
| byte_done_i | input | 1 | Byte complete, ninth SCL falling edge (one cycle) |
| rx_byte_i | input | BYTE_W | Byte just received |
| addr_we_i | input | 1 | Host write strobe on the comparison register |
| addr_wdata_i | input | BYTE_W | Value written by the host |
| upd_addr_o | output | 1 | Host must reload the comparison register |
| scl_hold_o | output | 1 | Request to hold SCL low |
| matched_o | output | 1 | Slave addressed, data phase may proceed |
| match_rd_o | output | 1 | Addressed transfer is a read |

## Verification
The interesting collisions occur when a bus event lands in the same cycle as a host write during a stretch. A Stop or Start competes with the write that would release SCL, and the question is both which one steers the state and whether the register still takes the written value. Directed cases place a Stop and a write together in HI_HOLD. They then resend a header, whose rejection shows that the register was loaded although the state went to IDLE. Random runs make all five event inputs coincide freely, and each cycle is judged against a bench model of the requirements' priority order.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_HDR     = 3'd1,
        S_HI_HOLD = 3'd2,
        S_LO_WAIT = 3'd3,
        S_LO_HOLD = 3'd4,
        S_WR_XFER = 3'd5,
        S_RS_HDR  = 3'd6,
        S_RD_XFER = 3'd7
    } seq_state_e;

    // bus event priority: stop above start above repeated start
    typedef struct packed {
        logic stop;
        logic start;
        logic rstart;
    } bus_evt_t;

endpackage

// File: rtl/i2c10_addr_reg.sv
module i2c10_addr_reg #(
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] RST_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] addr_o
);

    logic [BYTE_W-1:0] addr_q;

    // the write always lands, whatever the sequencer does with it
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= RST_ADDR;
        else if (we_i)
            addr_q <= wdata_i;
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/i2c10_addr_cmp.sv
module i2c10_addr_cmp #(
    parameter int               BYTE_W   = 8,
    parameter int               HDR_W    = 5,
    parameter logic [HDR_W-1:0] HDR_CODE = 5'b11110
) (
    input  logic [BYTE_W-1:0] rx_i,
    input  logic [BYTE_W-1:0] addr_i,
    output logic              hi_hit_o,
    output logic              lo_hit_o,
    output logic              rw_o
);

    localparam int ID_W = BYTE_W - 1;

    logic [BYTE_W-1:0] bit_eq;
    logic              prefix_ok;

    genvar g;
    generate
        for (g = 0; g < BYTE_W; g++) begin : g_bit
            assign bit_eq[g] = (rx_i[g] == addr_i[g]);
        end
    endgenerate

    assign prefix_ok = (rx_i[BYTE_W-1 -: HDR_W] == HDR_CODE);
    // high byte: marker plus upper address bits, the direction bit is excluded
    assign hi_hit_o  = prefix_ok && (&bit_eq[BYTE_W-1:1]);
    assign lo_hit_o  = &bit_eq;
    assign rw_o      = rx_i[0];

    initial begin
        assert (ID_W > HDR_W) else $error("header wider than byte");
    end

endmodule

// File: rtl/i2c10_seq_fsm.sv
module i2c10_seq_fsm
    import i2c10_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_evt_t evt_i,
    input  logic     byte_done_i,
    input  logic     hi_hit_i,
    input  logic     lo_hit_i,
    input  logic     rw_i,
    input  logic     addr_we_i,
    output logic     upd_addr_o,
    output logic     scl_hold_o,
    output logic     matched_o,
    output logic     match_rd_o
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (evt_i.stop) begin
            state_d = S_IDLE;
        end else if (evt_i.start) begin
            state_d = S_HDR;
        end else if (evt_i.rstart) begin
            state_d = (state_q == S_WR_XFER || state_q == S_RD_XFER) ? S_RS_HDR : S_HDR;
        end else begin
            unique case (state_q)
                S_IDLE:    state_d = S_IDLE;
                S_HDR:     if (byte_done_i)
                               state_d = (hi_hit_i && !rw_i) ? S_HI_HOLD : S_IDLE;
                S_HI_HOLD: if (addr_we_i) state_d = S_LO_WAIT;
                S_LO_WAIT: if (byte_done_i)
                               state_d = lo_hit_i ? S_LO_HOLD : S_IDLE;
                S_LO_HOLD: if (addr_we_i) state_d = S_WR_XFER;
                S_WR_XFER: state_d = S_WR_XFER;
                S_RS_HDR:  if (byte_done_i) begin
                               if (!hi_hit_i)
                                   state_d = S_IDLE;
                               else
                                   state_d = rw_i ? S_RD_XFER : S_HI_HOLD;
                           end
                S_RD_XFER: state_d = S_RD_XFER;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        upd_addr_o = 1'b0;
        scl_hold_o = 1'b0;
        matched_o  = 1'b0;
        match_rd_o = 1'b0;
        unique case (state_q)
            S_HI_HOLD, S_LO_HOLD: begin
                upd_addr_o = 1'b1;
                scl_hold_o = 1'b1;
            end
            S_WR_XFER: matched_o = 1'b1;
            S_RD_XFER: begin
                matched_o  = 1'b1;
                match_rd_o = 1'b1;
            end
            default: ;
        endcase
    end

    logic quiet;
    assign quiet = !evt_i.stop && !evt_i.start && !evt_i.rstart;

    // R9
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.stop |=> (!scl_hold_o && !upd_addr_o && !matched_o && !match_rd_o));

    // R4
    hold_until_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold_o && !addr_we_i && quiet) |=> scl_hold_o);

    // R4
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold_o && addr_we_i && quiet) |=> (!scl_hold_o && !upd_addr_o));

    // R2
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HDR && byte_done_i && hi_hit_i && !rw_i && quiet)
            |=> (scl_hold_o && upd_addr_o));

    // R7
    rd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_rd_o) |-> ($past(byte_done_i) && $past(rw_i) && !scl_hold_o));

    // R10
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.start && !evt_i.stop) |=> (!matched_o && !scl_hold_o));

endmodule

// File: rtl/i2c10_addr_seq.sv
module i2c10_addr_seq #(
    parameter int                BYTE_W   = 8,
    parameter int                HDR_W    = 5,
    parameter logic [HDR_W-1:0]  HDR_CODE = 5'b11110,
    parameter logic [BYTE_W-1:0] RST_ADDR = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rstart_i,
    input  logic              stop_i,
    input  logic              byte_done_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              addr_we_i,
    input  logic [BYTE_W-1:0] addr_wdata_i,
    output logic              upd_addr_o,
    output logic              scl_hold_o,
    output logic              matched_o,
    output logic              match_rd_o
);

    import i2c10_pkg::*;

    logic [BYTE_W-1:0] addr_q;
    logic              hi_hit, lo_hit, rw_bit;
    bus_evt_t          evt;

    assign evt.stop   = stop_i;
    assign evt.start  = start_i;
    assign evt.rstart = rstart_i;

    i2c10_addr_reg #(.BYTE_W(BYTE_W), .RST_ADDR(RST_ADDR)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (addr_we_i),
        .wdata_i (addr_wdata_i),
        .addr_o  (addr_q)
    );

    i2c10_addr_cmp #(.BYTE_W(BYTE_W), .HDR_W(HDR_W), .HDR_CODE(HDR_CODE)) u_cmp (
        .rx_i     (rx_byte_i),
        .addr_i   (addr_q),
        .hi_hit_o (hi_hit),
        .lo_hit_o (lo_hit),
        .rw_o     (rw_bit)
    );

    i2c10_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .byte_done_i (byte_done_i),
        .hi_hit_i    (hi_hit),
        .lo_hit_i    (lo_hit),
        .rw_i        (rw_bit),
        .addr_we_i   (addr_we_i),
        .upd_addr_o  (upd_addr_o),
        .scl_hold_o  (scl_hold_o),
        .matched_o   (matched_o),
        .match_rd_o  (match_rd_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!scl_hold_o && !upd_addr_o && !matched_o && !match_rd_o));

endmodule

// File: tb/sim_i2c10_addr_seq.sv
`timescale 1ns/1ps
module sim_i2c10_addr_seq;

    localparam logic [7:0] RST_A = 8'hF0;
    localparam logic [7:0] HI_A  = 8'hF4;
    localparam logic [7:0] LO_A  = 8'h5A;

    localparam int P_IDLE = 0, P_HDR = 1, P_HIH = 2, P_LOW = 3,
                   P_LOH = 4, P_WR = 5, P_RSH = 6, P_RD = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 0, rstart_i = 0, stop_i = 0, byte_done_i = 0, addr_we_i = 0;
    logic [7:0] rx_byte_i = '0, addr_wdata_i = '0;
    logic       upd_addr_o, scl_hold_o, matched_o, match_rd_o;

    int   n_chk = 0, n_fail = 0;
    int   ph;
    logic [7:0] mreg;
    bit   done = 0;

    always #2 clk = ~clk;

    i2c10_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rstart_i(rstart_i),
        .stop_i(stop_i), .byte_done_i(byte_done_i), .rx_byte_i(rx_byte_i),
        .addr_we_i(addr_we_i), .addr_wdata_i(addr_wdata_i),
        .upd_addr_o(upd_addr_o), .scl_hold_o(scl_hold_o),
        .matched_o(matched_o), .match_rd_o(match_rd_o)
    );

    function automatic logic [3:0] exp_out(int p);
        logic h;
        h = (p == P_HIH) || (p == P_LOH);
        return {h, h, (p == P_WR) || (p == P_RD), p == P_RD};
    endfunction

    function automatic bit hi_ok(logic [7:0] b, logic [7:0] r);
        return (b[7:3] == 5'b11110) && (b[7:1] == r[7:1]);
    endfunction

    function automatic int next_ph(int p, logic sp, logic st, logic rs, logic bd,
                                   logic [7:0] b, logic wr, logic [7:0] r);
        if (sp) return P_IDLE;
        if (st) return P_HDR;
        if (rs) return (p == P_WR || p == P_RD) ? P_RSH : P_HDR;
        case (p)
            P_HDR: if (bd) return (hi_ok(b, r) && !b[0]) ? P_HIH : P_IDLE;
            P_HIH: if (wr) return P_LOW;
            P_LOW: if (bd) return (b == r) ? P_LOH : P_IDLE;
            P_LOH: if (wr) return P_WR;
            P_RSH: if (bd) return !hi_ok(b, r) ? P_IDLE : (b[0] ? P_RD : P_HIH);
            default: ;
        endcase
        return p;
    endfunction

    task automatic chk(string tag);
        logic [3:0] act, exp;
        act = {scl_hold_o, upd_addr_o, matched_o, match_rd_o};
        exp = exp_out(ph);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {hold,upd,match,rd} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive one cycle of stimulus starting at a falling edge, return at the next one
    task automatic cyc(logic sp, logic st, logic rs, logic bd, logic [7:0] b,
                       logic wr, logic [7:0] wd);
        stop_i = sp; start_i = st; rstart_i = rs; byte_done_i = bd;
        rx_byte_i = b; addr_we_i = wr; addr_wdata_i = wd;
        ph = next_ph(ph, sp, st, rs, bd, b, wr, mreg);
        if (wr) mreg = wd;
        @(negedge clk);
        stop_i = 0; start_i = 0; rstart_i = 0; byte_done_i = 0; addr_we_i = 0;
    endtask

    task automatic idle1();           cyc(0,0,0,0,8'h00,0,8'h00); endtask
    task automatic wr1(logic [7:0] d); cyc(0,0,0,0,8'h00,1,d);     endtask
    task automatic bd1(logic [7:0] b); cyc(0,0,0,1,b,0,8'h00);     endtask
    task automatic st1();             cyc(0,1,0,0,8'h00,0,8'h00); endtask
    task automatic rs1();             cyc(0,0,1,0,8'h00,0,8'h00); endtask
    task automatic sp1();             cyc(1,0,0,0,8'h00,0,8'h00); endtask

    task automatic to_write_match();
        st1(); bd1(HI_A); wr1(LO_A); bd1(LO_A); wr1(HI_A);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        ph = P_IDLE; mreg = RST_A;
        repeat (3) @(negedge clk);
        chk("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset");

        wr1(HI_A);        chk("R11 idle write");
        st1();            chk("R10 start");
        bd1(HI_A);        chk("R2 header hold");
        idle1();          chk("R4 hold persists");
        wr1(LO_A);        chk("R4 write releases");
        bd1(LO_A);        chk("R5 low match hold");
        wr1(HI_A);        chk("R6 write match");
        bd1(8'h33);       chk("R6 data ignored");
        rs1();            chk("R7 rstart");
        bd1(HI_A | 8'h01); chk("R7 read match");
        bd1(8'hC3);       chk("R7 read persists");
        sp1();            chk("R9 stop");

        st1(); bd1(HI_A | 8'h01); chk("R3 read bit in first byte");
        bd1(HI_A);        chk("R3 later byte ignored");
        st1(); bd1(8'hE4); chk("R3 bad prefix");
        st1(); bd1(8'hF2); chk("R3 bad upper bits");

        st1(); bd1(HI_A); wr1(LO_A); bd1(LO_A ^ 8'h01); chk("R5 low mismatch");

        st1(); bd1(HI_A);
        cyc(1,0,0,0,8'h00,1,LO_A); chk("R9 stop beats write");
        st1(); bd1(HI_A);  chk("R9 write still loaded");
        wr1(HI_A);         chk("R11 restore");

        rs1(); bd1(HI_A);  chk("R12 rstart from idle");
        sp1();
        to_write_match(); rs1(); bd1(8'hF7); chk("R8 resend mismatch");
        to_write_match(); st1(); chk("R10 start drops match");
        to_write_match(); cyc(1,1,1,1,HI_A,0,8'h00); chk("R9 stop beats all");

        for (int i = 0; i < 6000; i++) begin
            logic sp, st, rs, bd, wr;
            logic [7:0] b, wd;
            int k;
            sp = ($urandom % 100) < 2;
            st = ($urandom % 100) < 4;
            rs = ($urandom % 100) < 4;
            bd = ($urandom % 100) < 35;
            wr = ($urandom % 100) < 20;
            k  = $urandom % 5;
            case (k)
                0: b = {mreg[7:1], 1'b0};
                1: b = {mreg[7:1], 1'b1};
                2: b = mreg;
                3: b = {HI_A[7:1], 1'b1};
                default: b = 8'($urandom);
            endcase
            k  = $urandom % 10;
            wd = (k == 0) ? 8'($urandom) : ((mreg == HI_A) ? LO_A : HI_A);
            cyc(sp, st, rs, bd, b, wr, wd);
            chk("R2-model random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule